// File: doc/BRIEF.md
# Manchester Word Encoder with Sync Character

This block turns a serial data word into a Manchester-coded bipolar line signal. Each word opens with a three-bit-time sync character, and the host chooses a command or a data sync for every word. It runs from a send clock at twice the bit rate, so one send-clock period is one half-bit cell on the line. It divides that clock by two to make a shift clock for the data source. A send-data enable tells the external source when to present bits. The bits are fetched just in time, one per shift-clock rising edge, and are not buffered. After the sixteenth data bit the block appends an odd-parity bit of its own.

The line is driven through two active-low outputs. One is asserted for the positive line state and the other for the negative line state. When the block is idle both stay high and the line floats. An active-low inhibit input forces both high at once, but the word sequence keeps running behind it. A synchronous master reset clears the divide-by-two stage and aborts any word.

Top module: `manch_word_enc`

## Requirements
- R1: `shift_clk` is high in the first cycle after reset and toggles on every send-clock edge from then on.
- R2: `start` is only acted on at an edge that ends an idle cycle in which `shift_clk` is low. At that edge a word begins, and its first half-cell has `shift_clk` high. While a word is running, `start` is ignored except at the edge that ends its last half-cell.
- R3: `sync_cmd` is sampled only at the edge where a word begins. High gives three positive half-cells followed by three negative ones. Low gives three negative half-cells followed by three positive ones.
- R4: The data bits are sent MSB first in half-cells 6 to 37, counting the first sync half-cell as 0. A one is sent as a positive half-cell then a negative one; a zero as negative then positive. The positive state drives `one_n` low and `zero_n` high. The negative state drives `zero_n` low and `one_n` high.
- R5: `send_en` is high for exactly the 32 cycles of half-cells 4 to 35. `ser_in` is captured at each `shift_clk` rising edge that ends a cycle in which `send_en` is high, and the n-th capture is data bit n (MSB first).
- R6: Half-cells 38 and 39 carry a parity bit chosen so that the 16 data bits plus the parity bit hold an odd number of ones. It is encoded the same way as a data bit.
- R7: While no word is running, `one_n` and `zero_n` are both high and `send_en` is low.
- R8: While `inhibit_n` is low, `one_n` and `zero_n` are both high in that same cycle. The word timing carries on unchanged, and the line state resumes when `inhibit_n` returns high.
- R9: `rst` high at a clock edge ends any word and returns the block to idle, with `shift_clk` high in the next cycle.
- R10: If `start` is high at the edge that ends half-cell 39, the next word's sync begins in the very next cycle, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Send clock, twice the bit rate |
| rst | input | 1 | Synchronous master reset, active high |
| start | input | 1 | Encoder enable, requests a word |
| sync_cmd | input | 1 | High selects command sync, low selects data sync |
| ser_in | input | 1 | Serial data from the external source |
| inhibit_n | input | 1 | Active-low output inhibit |
| shift_clk | output | 1 | Shift clock at the bit rate |
| send_en | output | 1 | High while serial data is wanted |
| one_n | output | 1 | Active-low drive for the positive line state |
| zero_n | output | 1 | Active-low drive for the negative line state |

## Verification
The last parity half-cell of one word and the acceptance of the next word can fall on the same clock edge. The bench provokes this by raising `start` before half-cell 38 ends and holding it there. The per-cycle reference model then expects the new sync's first half-cell in the cycle right after half-cell 39. It also expects `shift_clk` to keep toggling without a break, and any stall or extra idle cycle shows up as a mismatch. In a second case, inhibit pulses overlap both the sync character and the data fetch window. The model checks that the captured bits and the parity are still correct once the line comes back.

// File: rtl/manch_pkg.sv
package manch_pkg;

    // half-cells spent on the sync character
    localparam int SYNC_HALVES = 6;

    // counter width for a word of dw data bits plus sync and parity
    function automatic int cnt_bits(int dw);
        return $clog2(SYNC_HALVES + 2 * dw + 2);
    endfunction

    // line level of a Manchester cell: the first half follows the bit, the second half inverts it
    function automatic logic half_level(logic bit_v, logic second_half);
        return bit_v ^ second_half;
    endfunction

endpackage

// File: rtl/manch_timer.sv
module manch_timer #(
    parameter int DATA_W = 16,
    localparam int PAR_H = manch_pkg::SYNC_HALVES + 2 * DATA_W,
    localparam int LAST_H = PAR_H + 1,
    localparam int FETCH_LO = manch_pkg::SYNC_HALVES - 2,
    localparam int FETCH_HI = PAR_H - 3,
    localparam int CNT_W = manch_pkg::cnt_bits(DATA_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sync_cmd,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             cmd,
    output logic             shift_clk,
    output logic             begin_word,
    output logic             take_bit,
    output logic             load_par,
    output logic             send_en
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             cmd;
        logic             phase;
    } tmr_t;

    tmr_t s_q, s_d;
    logic at_end;
    logic go;

    always_comb begin
        s_d = s_q;
        s_d.phase = ~s_q.phase;
        at_end = s_q.busy && (s_q.cnt == CNT_W'(LAST_H));
        go = start && s_q.phase && (!s_q.busy || at_end);
        if (go) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.cmd  = sync_cmd;
        end else if (at_end) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign busy       = s_q.busy;
    assign cnt        = s_q.cnt;
    assign cmd        = s_q.cmd;
    assign shift_clk  = ~s_q.phase;
    assign begin_word = go;
    assign send_en    = s_q.busy && (s_q.cnt >= CNT_W'(FETCH_LO)) && (s_q.cnt <= CNT_W'(FETCH_HI));
    assign take_bit   = send_en && s_q.cnt[0];
    assign load_par   = s_q.busy && (s_q.cnt == CNT_W'(PAR_H - 1));

endmodule

// File: rtl/manch_datapath.sv
module manch_datapath (
    input  logic clk,
    input  logic rst,
    input  logic begin_word,
    input  logic take_bit,
    input  logic load_par,
    input  logic ser_in,
    output logic cur_bit
);

    typedef struct packed {
        logic bitv;
        logic par;
    } dp_t;

    dp_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (begin_word) s_d.par = 1'b1;
        if (take_bit) begin
            s_d.bitv = ser_in;
            s_d.par  = s_q.par ^ ser_in;
        end
        if (load_par) s_d.bitv = s_q.par;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cur_bit = s_q.bitv;

endmodule

// File: rtl/manch_drive.sv
module manch_drive #(
    parameter int DATA_W = 16,
    localparam int CNT_W = manch_pkg::cnt_bits(DATA_W),
    localparam int HALF_SYNC = manch_pkg::SYNC_HALVES / 2
) (
    input  logic             busy,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cmd,
    input  logic             cur_bit,
    input  logic             inhibit_n,
    output logic             one_n,
    output logic             zero_n
);

    logic pos;
    logic drive;

    always_comb begin
        if (cnt < CNT_W'(HALF_SYNC))
            pos = cmd;
        else if (cnt < CNT_W'(manch_pkg::SYNC_HALVES))
            pos = ~cmd;
        else
            pos = manch_pkg::half_level(cur_bit, cnt[0]);
        drive  = busy && inhibit_n;
        one_n  = ~(drive && pos);
        zero_n = ~(drive && !pos);
    end

endmodule

// File: rtl/manch_word_enc.sv
module manch_word_enc #(
    parameter int DATA_W = 16,
    localparam int CNT_W = manch_pkg::cnt_bits(DATA_W)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic sync_cmd,
    input  logic ser_in,
    input  logic inhibit_n,
    output logic shift_clk,
    output logic send_en,
    output logic one_n,
    output logic zero_n
);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             cmd;
    logic             begin_word;
    logic             take_bit;
    logic             load_par;
    logic             cur_bit;

    manch_timer #(.DATA_W(DATA_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .sync_cmd   (sync_cmd),
        .busy       (busy),
        .cnt        (cnt),
        .cmd        (cmd),
        .shift_clk  (shift_clk),
        .begin_word (begin_word),
        .take_bit   (take_bit),
        .load_par   (load_par),
        .send_en    (send_en)
    );

    manch_datapath u_dp (
        .clk        (clk),
        .rst        (rst),
        .begin_word (begin_word),
        .take_bit   (take_bit),
        .load_par   (load_par),
        .ser_in     (ser_in),
        .cur_bit    (cur_bit)
    );

    manch_drive #(.DATA_W(DATA_W)) u_drive (
        .busy      (busy),
        .cnt       (cnt),
        .cmd       (cmd),
        .cur_bit   (cur_bit),
        .inhibit_n (inhibit_n),
        .one_n     (one_n),
        .zero_n    (zero_n)
    );

endmodule

// File: rtl/manch_word_enc_chk.sv
module manch_word_enc_chk (
    input logic clk,
    input logic rst,
    input logic inhibit_n,
    input logic shift_clk,
    input logic send_en,
    input logic one_n,
    input logic zero_n
);

    logic armed_q = 1'b0;

    always_ff @(posedge clk) armed_q <= 1'b1;

    // R8
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !inhibit_n |-> (one_n && zero_n));

    // R1
    shift_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (shift_clk != $past(shift_clk)));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        (armed_q && $past(rst)) |-> (one_n && zero_n && !send_en && shift_clk));

    // R4
    manch_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (send_en && $past(send_en) && $past(send_en, 2) && !shift_clk && inhibit_n && $past(inhibit_n))
        |-> (one_n == $past(zero_n) && zero_n == $past(one_n)));

    // R5
    fetch_align_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(send_en) || $fell(send_en)) |-> shift_clk);

endmodule

bind manch_word_enc manch_word_enc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .inhibit_n (inhibit_n),
    .shift_clk (shift_clk),
    .send_en   (send_en),
    .one_n     (one_n),
    .zero_n    (zero_n)
);

// File: tb/test_manch_word_enc.sv
module test_manch_word_enc;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int WORD_H = 6 + 2 * DATA_W + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic sync_cmd = 1'b0;
    logic ser_in = 1'b0;
    logic inhibit_n = 1'b1;
    logic shift_clk, send_en, one_n, zero_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    manch_word_enc #(.DATA_W(DATA_W)) i_manch_word_enc (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .sync_cmd  (sync_cmd),
        .ser_in    (ser_in),
        .inhibit_n (inhibit_n),
        .shift_clk (shift_clk),
        .send_en   (send_en),
        .one_n     (one_n),
        .zero_n    (zero_n)
    );

    int checks = 0;
    int errors = 0;
    int m_pos = -1;
    bit m_ph = 1'b0;
    bit m_b2b = 1'b0;
    int m_pol[$];
    logic [DATA_W-1:0] m_word = '0;
    logic [DATA_W-1:0] wq[$];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic build_word();
        int ones;
        bit p;
        m_word = (wq.size() > 0) ? wq.pop_front() : '0;
        m_pol.delete();
        repeat (3) m_pol.push_back(int'(sync_cmd));
        repeat (3) m_pol.push_back(int'(!sync_cmd));
        for (int i = DATA_W - 1; i >= 0; i--) begin
            m_pol.push_back(int'(m_word[i]));
            m_pol.push_back(int'(!m_word[i]));
        end
        ones = $countones(m_word);
        p = (ones % 2 == 0);
        m_pol.push_back(int'(p));
        m_pol.push_back(int'(!p));
    endtask

    task automatic model_edge();
        bit prev;
        prev = m_ph;
        if (rst) begin
            m_pos = -1;
            m_ph = 1'b0;
            m_b2b = 1'b0;
            return;
        end
        m_ph = !m_ph;
        if (m_pos == -1 || m_pos == WORD_H - 1) begin
            if (start && prev) begin
                m_b2b = (m_pos == WORD_H - 1);
                m_pos = 0;
                build_word();
            end else begin
                m_pos = -1;
            end
        end else begin
            m_pos++;
        end
        if (m_pos >= 6) m_b2b = 1'b0;
    endtask

    task automatic compare();
        int pol;
        bit e_one, e_zero, e_send;
        string rq;
        e_send = (m_pos >= 4 && m_pos <= WORD_H - 5);
        pol = (m_pos >= 0) ? m_pol[m_pos] : -1;
        e_one = !(inhibit_n && pol == 1);
        e_zero = !(inhibit_n && pol == 0);
        if (!inhibit_n)              rq = "R8";
        else if (m_pos < 0)          rq = start ? "R2" : "R7";
        else if (m_pos < 6)          rq = m_b2b ? "R10" : "R3";
        else if (m_pos >= WORD_H - 2) rq = "R6";
        else                         rq = "R4";
        chk(one_n === e_one && zero_n === e_zero, rq, "one_n,zero_n",
            int'({one_n, zero_n}), int'({e_one, e_zero}));
        chk(shift_clk === !m_ph, "R1", "shift_clk", int'(shift_clk), int'(!m_ph));
        chk(send_en === e_send, "R5", "send_en", int'(send_en), int'(e_send));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        if (m_pos >= 4 && m_pos <= WORD_H - 5)
            ser_in = m_word[DATA_W - 1 - (m_pos - 4) / 2];
        else
            ser_in = 1'b0;
    endtask

    task automatic run_word(logic [DATA_W-1:0] w, bit cmd, bit chain, bit inh_pulse);
        wq.push_back(w);
        sync_cmd = cmd;
        start = 1'b1;
        do step(); while (m_pos != 0);
        start = 1'b0;
        sync_cmd = !cmd;  // R3: ignored after the word began
        while (m_pos != WORD_H - 2) begin
            step();
            if (m_pos == 10) start = 1'b1;  // R2: ignored while busy
            if (m_pos == 12) start = 1'b0;
            if (inh_pulse)
                inhibit_n = !((m_pos >= 1 && m_pos < 4) || (m_pos >= 14 && m_pos < 20));
        end
        inhibit_n = 1'b1;
        start = chain;
        step();
    endtask

    task automatic drain();
        start = 1'b0;
        while (m_pos != -1) step();
        repeat (3) step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        // R9 reset state
        chk(one_n && zero_n && !send_en && shift_clk, "R9", "reset state",
            int'({one_n, zero_n, send_en, shift_clk}), 4'b1101);
        rst = 1'b0;
        repeat (5) step();
        // R7 idle with no request
        chk(one_n && zero_n && !send_en, "R7", "idle lines",
            int'({one_n, zero_n, send_en}), 3'b110);

        run_word(16'hA5C3, 1'b1, 1'b0, 1'b0);
        drain();
        run_word(16'h0000, 1'b0, 1'b0, 1'b0);
        drain();
        step();  // shift the phase at which start rises (R2)
        run_word(16'hFFFF, 1'b1, 1'b1, 1'b0);
        run_word(16'h8001, 1'b0, 1'b1, 1'b0);  // R10 chained
        run_word(16'h1234, 1'b1, 1'b0, 1'b1);  // R8 inhibit pulses
        drain();

        // R9 reset in the middle of a word
        wq.push_back(16'hBEEF);
        sync_cmd = 1'b0;
        start = 1'b1;
        do step(); while (m_pos != 0);
        start = 1'b0;
        repeat (20) step();
        rst = 1'b1;
        repeat (2) step();
        chk(one_n && zero_n && !send_en && shift_clk, "R9", "mid-word reset",
            int'({one_n, zero_n, send_en, shift_clk}), 4'b1101);
        rst = 1'b0;
        repeat (3) step();
        run_word(16'h7F0E, 1'b0, 1'b0, 1'b0);
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule